// File: doc/BRIEF.md
# Counter/Timer Bus Front End with Interrupt Priority Chain

This block sits between an 8-bit processor bus and a four-channel counter/timer. It has no separate write pin. It reads the cycle type from three active-low inputs: the I/O request, the chip enable and the read strobe. A write is an I/O request with chip enable while the read strobe is inactive, so the write strobe is the inverse of a qualified read. A write loads the selected channel's down-counter register, or the shared interrupt vector base. A read drives the selected channel's count onto the output data bus and raises the bus output enable.

Each channel has an interrupt source input. A pulse on that input marks the channel pending. The block joins a priority daisy chain through an active-high enable input and an active-high enable output. An I/O request together with the active-low M1 input is an interrupt acknowledge. In that cycle the highest-priority eligible channel places its vector on the bus. That channel then leaves the pending state and enters the under-service state. It stays there until its clear-service input is pulsed. While any channel is under service, the enable output blocks all devices further down the chain.

The counter cores are not part of this block. They are represented by plain loadable registers.

Top module: `ctc_bus_front`

## Requirements
- R1: After a synchronous active-low reset:
    - all count registers and the vector base are zero;
    - no channel is pending or under service;
    - `irq_n` is 1 and `data_oe` is 0;
    - `ien_out` equals `ien_in`.
- R2: When `iorq_n`=0, `ce_n`=0, `rd_n`=1 and `m1_n`=1 at a rising clock edge, `data_in` is written into the count register of channel `sel`. R3 gives the single exception. The same pattern with `ce_n`=1 or `iorq_n`=1 changes nothing.
- R3: A write to channel 0 whose `data_in[0]` is 0 loads the vector base from `data_in[7:3]`. Channel 0's count register is left unchanged in that case.
- R4: When `iorq_n`=0, `ce_n`=0, `rd_n`=0 and `m1_n`=1, `data_out` carries the count register of channel `sel` and `data_oe` is 1 in the same cycle. A value written at one edge can be read in the cycle after that edge.
- R5: `data_oe` is 1 only during a read cycle (R4) or during an acknowledge to which this device responds (R7). It is 0 in every other cycle, including write cycles and any cycle with `iorq_n`=1.
- R6: A one-cycle pulse on `irq_src[i]` makes channel i pending from the next edge. `irq_n` is 0 while some eligible channel is pending and `ien_in`=1. A channel is eligible when neither it nor any channel with a lower index is under service. `irq_n` is 1 whenever `ien_in`=0.
- R7: An acknowledge cycle is `iorq_n`=0 with `m1_n`=0. In it, the eligible pending channel with the lowest index (channel 0 is highest priority) drives the vector `{base[4:0], ch[1:0], 1'b0}` with `data_oe`=1. The vector is present from the first cycle and is held unchanged for as long as the acknowledge lasts.
- R8: An acknowledge with `ien_in`=0, or with no eligible pending channel, leaves `data_oe` at 0. It does not change the pending or service state.
- R9: The acknowledged channel moves from pending to under service. It stays under service until a one-cycle pulse on `clr_srv[i]`, which clears it at the next edge.
- R10: A channel under service blocks every lower-priority channel from requesting or being acknowledged. A higher-priority channel can still request and be acknowledged.
- R11: `ien_out` is 1 exactly when `ien_in` is 1 and no channel of this device is under service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus inputs are sampled synchronously |
| rst_n | input | 1 | Synchronous active-low reset |
| iorq_n | input | 1 | I/O request, active low |
| ce_n | input | 1 | Chip enable, active low |
| rd_n | input | 1 | Read strobe, active low |
| m1_n | input | 1 | Opcode-fetch marker, active low; with `iorq_n` it marks an acknowledge |
| sel | input | 2 | Channel select for reads and writes |
| data_in | input | 8 | Write data from the bus |
| data_out | output | 8 | Read data or interrupt vector |
| data_oe | output | 1 | Output enable for the tri-state bus driver |
| irq_src | input | 4 | Per-channel interrupt request pulses from the counter cores |
| clr_srv | input | 4 | Per-channel end-of-service pulses |
| ien_in | input | 1 | Daisy-chain enable in, active high |
| ien_out | output | 1 | Daisy-chain enable out, active high |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The decoder is driven with each of the four strobe combinations: write, read, acknowledge, and write with the chip enable or I/O request inactive. This separates a proper write strobe from one that fires on any I/O request. Reads back on every channel show that `sel` steers both the store and the return path.

The priority logic is tested with these patterns:
- two channels pending at once, which shows that the lowest index wins;
- a lower channel pending behind one under service, which must be refused;
- a higher channel arriving during service, which must win;
- acknowledges with the chain enable low, which must leave all state untouched.

Even and odd writes to channel 0 distinguish a vector-base load from a count load.

// File: rtl/ctc_pkg.sv
// Package: shared constants and the decoded bus-cycle type for the
// counter/timer bus front end. Assumes an 8-bit bus and four channels
// by default.
package ctc_pkg;
    localparam int DW  = 8;
    localparam int NCH = 4;

    // One flag per recognised bus cycle; at most one is set at a time.
    typedef struct packed {
        logic wr;
        logic rd;
        logic ack;
    } bus_cyc_t;
endpackage

// File: rtl/ctc_bus_decode.sv
// Module: ctc_bus_decode
// Purpose: turns the active-low bus strobes into write, read and
// acknowledge flags. There is no write pin: a write is an I/O request
// with chip enable while the read strobe is idle. Assumes the strobes
// are already synchronous to clk.
module ctc_bus_decode
    import ctc_pkg::*;
(
    input  logic     iorq_n,
    input  logic     ce_n,
    input  logic     rd_n,
    input  logic     m1_n,
    output bus_cyc_t cyc
);
    logic io_sel;

    // Decode the cycle type from the strobe combination.
    always_comb begin
        io_sel  = !iorq_n && !ce_n && m1_n;
        cyc.wr  = io_sel && rd_n;
        cyc.rd  = io_sel && !rd_n;
        cyc.ack = !iorq_n && !m1_n;
    end
endmodule

// File: rtl/ctc_chan_regs.sv
// Module: ctc_chan_regs
// Purpose: holds the per-channel count registers, which stand in for
// the counter cores, and the shared vector base. An even write to
// channel 0 loads the base; every other write loads a count.
// Assumes a synchronous active-low reset.
module ctc_chan_regs #(
    parameter int DW  = 8,
    parameter int NCH = 4,
    localparam int CHW = $clog2(NCH),
    localparam int BW  = DW - 1 - CHW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic [CHW-1:0] sel,
    input  logic [DW-1:0]  din,
    output logic [DW-1:0]  count_sel,
    output logic [BW-1:0]  vbase
);
    logic [DW-1:0] count_q [NCH];
    logic          base_wr;

    // Identify a vector-base write.
    always_comb base_wr = wr && (sel == '0) && !din[0];

    // Load the vector base on an even write to channel 0.
    always_ff @(posedge clk) begin
        if (!rst_n)       vbase <= '0;
        else if (base_wr) vbase <= din[DW-1:DW-BW];
    end

    // One count register per channel.
    for (genvar c = 0; c < NCH; c++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n)
                count_q[c] <= '0;
            else if (wr && !base_wr && (sel == CHW'(c)))
                count_q[c] <= din;
        end
    end

    // Return path for reads.
    always_comb count_sel = count_q[sel];

    // A base write must never disturb channel 0's count.
    p_base_keeps_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> $stable(count_q[0]));
endmodule

// File: rtl/ctc_int_chain.sv
// Module: ctc_int_chain
// Purpose: keeps the pending and under-service flags of each channel,
// runs the internal priority chain (channel 0 highest), picks the
// channel that answers an acknowledge and holds that choice while the
// acknowledge lasts. Assumes pulse inputs last one cycle and a
// synchronous active-low reset.
module ctc_int_chain #(
    parameter int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ack,
    input  logic           ien_in,
    input  logic [NCH-1:0] irq_src,
    input  logic [NCH-1:0] clr_srv,
    output logic           irq_any,
    output logic           vec_hit,
    output logic [CHW-1:0] vec_ch,
    output logic           any_srv
);
    logic [NCH-1:0] pend_q, srv_q, elig, grant;
    logic           ack_d, ack_new, hit_q;
    logic [CHW-1:0] ch_q, win_ch;

    // Eligibility: pending, chain enabled, and no service at or above.
    always_comb begin
        logic blocked;
        blocked = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            blocked = blocked | srv_q[i];
            elig[i] = pend_q[i] && ien_in && !blocked;
        end
    end

    // Priority pick of the lowest-index eligible channel.
    always_comb begin
        win_ch = '0;
        for (int i = NCH - 1; i >= 0; i--)
            if (elig[i]) win_ch = CHW'(i);
    end

    // Grant only on the first cycle of an acknowledge.
    always_comb begin
        ack_new = ack && !ack_d;
        grant   = '0;
        if (ack_new && |elig) grant[win_ch] = 1'b1;
    end

    // Pending flags: set by a source pulse, cleared by a grant.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~grant) | irq_src;
    end

    // Service flags: set by a grant, cleared by the end-of-service pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) srv_q <= '0;
        else        srv_q <= (srv_q | grant) & ~clr_srv;
    end

    // Remember the answered channel for the rest of the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_d <= 1'b0;
            hit_q <= 1'b0;
            ch_q  <= '0;
        end else begin
            ack_d <= ack;
            if (ack_new) begin
                hit_q <= |elig;
                ch_q  <= win_ch;
            end else if (!ack) begin
                hit_q <= 1'b0;
            end
        end
    end

    // Outputs to the top level.
    always_comb begin
        irq_any = |elig;
        any_srv = |srv_q;
        vec_hit = ack && (ack_new ? |elig : hit_q);
        vec_ch  = ack_new ? win_ch : ch_q;
    end

    p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_vec_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ack_d && vec_hit) |-> $stable(vec_ch));
    p_grant_serviced_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant && !(|clr_srv)) |=> any_srv);
    p_no_grant_chain_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_in |-> (grant == '0));
endmodule

// File: rtl/ctc_bus_front.sv
// Module: ctc_bus_front
// Purpose: top level of the counter/timer bus front end. It joins the
// strobe decoder, the channel registers and the interrupt chain, and it
// muxes read data or the vector onto the output bus. Assumes the bus
// inputs are synchronous to clk and a synchronous active-low reset.
module ctc_bus_front
    import ctc_pkg::*;
#(
    parameter int DW  = ctc_pkg::DW,
    parameter int NCH = ctc_pkg::NCH,
    localparam int CHW = $clog2(NCH),
    localparam int BW  = DW - 1 - CHW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           iorq_n,
    input  logic           ce_n,
    input  logic           rd_n,
    input  logic           m1_n,
    input  logic [CHW-1:0] sel,
    input  logic [DW-1:0]  data_in,
    output logic [DW-1:0]  data_out,
    output logic           data_oe,
    input  logic [NCH-1:0] irq_src,
    input  logic [NCH-1:0] clr_srv,
    input  logic           ien_in,
    output logic           ien_out,
    output logic           irq_n
);
    bus_cyc_t       cyc;
    logic [DW-1:0]  count_sel;
    logic [BW-1:0]  vbase;
    logic           irq_any, vec_hit, any_srv;
    logic [CHW-1:0] vec_ch;

    ctc_bus_decode u_dec (
        .iorq_n (iorq_n),
        .ce_n   (ce_n),
        .rd_n   (rd_n),
        .m1_n   (m1_n),
        .cyc    (cyc)
    );

    ctc_chan_regs #(.DW(DW), .NCH(NCH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cyc.wr),
        .sel       (sel),
        .din       (data_in),
        .count_sel (count_sel),
        .vbase     (vbase)
    );

    ctc_int_chain #(.NCH(NCH)) u_int (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (cyc.ack),
        .ien_in  (ien_in),
        .irq_src (irq_src),
        .clr_srv (clr_srv),
        .irq_any (irq_any),
        .vec_hit (vec_hit),
        .vec_ch  (vec_ch),
        .any_srv (any_srv)
    );

    // Bus output: the count on reads, otherwise the vector.
    always_comb begin
        data_out = cyc.rd ? count_sel : {vbase, vec_ch, 1'b0};
        data_oe  = cyc.rd || (cyc.ack && vec_hit);
    end

    // Daisy-chain and request outputs.
    always_comb begin
        ien_out = ien_in && !any_srv;
        irq_n   = !irq_any;
    end

    p_oe_valid_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!iorq_n && ((!ce_n && !rd_n && m1_n) || !m1_n)));
    p_vector_lsb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && !m1_n) |-> !data_out[0]);
    p_ieo_follows_iei_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ien_out |-> ien_in);
    p_no_irq_chain_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_in |-> irq_n);
endmodule

// File: tb/ctc_bus_front_tb_top.sv
// Directed bench for ctc_bus_front. Inputs are driven on the falling
// edge and outputs are sampled 1 ns later.
module ctc_bus_front_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iorq_n = 1'b1, ce_n = 1'b1, rd_n = 1'b1, m1_n = 1'b1;
    logic [1:0] sel = '0;
    logic [7:0] data_in = '0;
    logic [7:0] data_out;
    logic       data_oe, ien_out, irq_n;
    logic [3:0] irq_src = '0, clr_srv = '0;
    logic       ien_in = 1'b1;

    int checks = 0;
    int failures = 0;

    ctc_bus_front dut_i (
        .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .ce_n(ce_n), .rd_n(rd_n),
        .m1_n(m1_n), .sel(sel), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .irq_src(irq_src), .clr_srv(clr_srv),
        .ien_in(ien_in), .ien_out(ien_out), .irq_n(irq_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        iorq_n = 1'b1; ce_n = 1'b1; rd_n = 1'b1; m1_n = 1'b1;
        irq_src = '0; clr_srv = '0;
    endtask

    task automatic bus_write(input logic [1:0] s, input logic [7:0] d, input logic ce_v);
        @(negedge clk);
        iorq_n = 1'b0; ce_n = ce_v; rd_n = 1'b1; m1_n = 1'b1; sel = s; data_in = d;
        #1 check("R5 oe during write", data_oe, 0);
        @(negedge clk); idle();
    endtask

    task automatic bus_read(input logic [1:0] s, input logic [7:0] exp, input string tag);
        @(negedge clk);
        iorq_n = 1'b0; ce_n = 1'b0; rd_n = 1'b0; m1_n = 1'b1; sel = s;
        #1;
        check(tag, data_out, exp);
        check("R4 oe on read", data_oe, 1);
        @(negedge clk); idle();
    endtask

    // Two-cycle acknowledge: check the first cycle and the held cycle.
    task automatic ack_cycle(input logic exp_oe, input logic [7:0] exp_vec, input string tag);
        @(negedge clk);
        iorq_n = 1'b0; m1_n = 1'b0; ce_n = 1'b1; rd_n = 1'b1;
        #1;
        check({tag, " oe"}, data_oe, exp_oe);
        if (exp_oe) check({tag, " vec"}, data_out, exp_vec);
        @(negedge clk); #1;
        check({tag, " oe held"}, data_oe, exp_oe);
        if (exp_oe) check({tag, " vec held"}, data_out, exp_vec);
        @(negedge clk); idle();
    endtask

    task automatic pulse_src(input logic [3:0] m);
        @(negedge clk); irq_src = m;
        @(negedge clk); irq_src = '0;
    endtask

    task automatic pulse_clr(input logic [3:0] m);
        @(negedge clk); clr_srv = m;
        @(negedge clk); clr_srv = '0;
    endtask

    task automatic t_reset();
        #1;
        check("R1 irq_n", irq_n, 1);
        check("R1 oe", data_oe, 0);
        check("R1 ien_out", ien_out, 1);
        bus_read(2'd3, 8'h00, "R1 count zero");
        ack_cycle(1'b0, 8'h00, "R1 nothing pending");
    endtask

    task automatic t_write_read();
        bus_write(2'd0, 8'h35, 1'b0);
        bus_write(2'd1, 8'h5A, 1'b0);
        bus_write(2'd2, 8'hC3, 1'b0);
        bus_write(2'd3, 8'h7E, 1'b0);
        bus_read(2'd0, 8'h35, "R2 ch0");
        bus_read(2'd1, 8'h5A, "R2 ch1");
        bus_read(2'd2, 8'hC3, "R2 ch2");
        bus_read(2'd3, 8'h7E, "R4 ch3");
        bus_write(2'd2, 8'h11, 1'b1);
        bus_read(2'd2, 8'hC3, "R2 ce high ignored");
        @(negedge clk); iorq_n = 1'b1; ce_n = 1'b0; rd_n = 1'b1; sel = 2'd1; data_in = 8'h99;
        #1 check("R5 oe no iorq", data_oe, 0);
        @(negedge clk); idle();
        bus_read(2'd1, 8'h5A, "R2 iorq high ignored");
    endtask

    task automatic t_vector_base();
        bus_write(2'd0, 8'hA0, 1'b0);
        bus_read(2'd0, 8'h35, "R3 ch0 count kept");
    endtask

    task automatic t_interrupts();
        ien_in = 1'b0;
        pulse_src(4'b0100);
        #1 check("R6 irq blocked by chain", irq_n, 1);
        ack_cycle(1'b0, 8'h00, "R8 ack chain off");
        ien_in = 1'b1;
        #1 check("R6 irq asserted", irq_n, 0);
        pulse_src(4'b0010);
        ack_cycle(1'b1, 8'hA2, "R7 ch1 wins");
        #1 check("R11 ien_out low in service", ien_out, 0);
        check("R10 ch2 blocked irq", irq_n, 1);
        ack_cycle(1'b0, 8'h00, "R10 ch2 blocked ack");
        pulse_src(4'b0001);
        #1 check("R10 ch0 requests", irq_n, 0);
        ack_cycle(1'b1, 8'hA0, "R10 ch0 acked");
        pulse_clr(4'b0001);
        #1 check("R9 still in service", ien_out, 0);
        pulse_clr(4'b0010);
        #1 check("R9 ch2 released", irq_n, 0);
        ack_cycle(1'b1, 8'hA4, "R7 ch2 acked");
        ien_in = 1'b0;
        #1 check("R11 ien_in low", ien_out, 0);
        ien_in = 1'b1;
        pulse_clr(4'b0100);
        #1 check("R11 ien_out restored", ien_out, 1);
        check("R9 nothing pending", irq_n, 1);
        ack_cycle(1'b0, 8'h00, "R8 nothing eligible");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_vector_base();
        t_interrupts();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule